// File: doc/BRIEF.md
# Strobed Serial Configuration Register Port

This block takes a configuration word over a three-wire serial link and transfers it into one of two parallel holding registers. Data bits arrive on `sdi` and are shifted in on each rising edge of `sck`, with the most significant bit first. A rising edge on `str` then commits the shifted word. The final bit shifted in, bit 0, selects the destination. When it is 1 the word goes to the control register. When it is 0 the word goes to the run-time register. The `wlock` input protects the control register: while it is high, control writes are dropped. Run-time writes are never locked.

`sdo` always shows the bit at the far end of the shift register, so devices can be chained on a shared strobe. On a strobe, the shift register is reloaded with the current contents of the register the word addressed. Shifting out the next 20 bits therefore reads that register back. All four serial pins are brought into the system clock domain through synchronizer flops before any edge is detected. A strobe is accepted only while `sck` is high, which follows the setup and hold rule on the serial link.

Top module: `cfg_serial_port`

## Requirements
- R1: After a synchronous active-low reset, the control register, the run-time register and the shift register are all zero, so `sdo` reads 0.
- R2: Each rising `sck` edge shifts the shift register toward its most significant end and inserts `sdi` at bit 0. `sdo` shows bit 19, so a shifted word leaves on `sdo` most significant bit first.
- R3: On a rising `str` edge with `sck` high, a word with bit 0 = 1 is copied into the control register when `wlock` is low.
- R4: While `wlock` is high, a strobed word with bit 0 = 1 leaves the control register unchanged.
- R5: On a rising `str` edge with `sck` high, a word with bit 0 = 0 is copied into the run-time register, whatever the level of `wlock`.
- R6: After a strobe, the shift register holds the latched contents of the register the word addressed. After a locked control write, these are the old control contents.
- R7: A rising `str` edge while `sck` is low changes neither holding register and leaves the shift register contents in place.
- R8: A write to one holding register never changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial data in |
| sck | input | 1 | Serial shift clock (rising edge shifts) |
| str | input | 1 | Strobe; rising edge commits the shifted word |
| wlock | input | 1 | High blocks control-register writes |
| sdo | output | 1 | Serial data out, far end of the shift register |
| ctrl_q | output | 20 | Control register contents |
| run_q | output | 20 | Run-time register contents |

## Verification
The hardest case to reach is a strobe that arrives while `sck` is low. A normal serial transfer always leaves `sck` high, and lowering and raising it again shifts in a stray bit. The bench therefore shifts 19 bits and drops `sck` with the last data bit already on `sdi`. It pulses `str` inside that low phase and only then raises `sck` to finish the word. A full readback over `sdo` then shows that the word arrived intact and that neither register moved. The locked control write is checked the same way, by reading back the reloaded shift register and confirming it carries the old control value.

// File: rtl/cfg_serial_pkg.sv
// Package: shared constants and types for the serial configuration port.
// Assumes: word width is fixed per instance; bit 0 of a word selects the target.
package cfg_serial_pkg;
    localparam int unsigned CFG_WORD_W   = 20;
    localparam int unsigned CFG_SYNC_LEN = 2;

    typedef enum logic {
        TGT_RUN  = 1'b0,
        TGT_CTRL = 1'b1
    } cfg_target_e;

    // Decode the destination from the select bit of a shifted word.
    function automatic cfg_target_e target_of(input logic sel_bit);
        return sel_bit ? TGT_CTRL : TGT_RUN;
    endfunction
endpackage

// File: rtl/cfg_pin_sync.sv
// Module: cfg_pin_sync
// Brings a bundle of asynchronous pins into the clk domain with a flop chain.
// Assumes: each pin is stable for several clk periods per level (slow serial link),
// so per-bit synchronization keeps the bits coherent.
module cfg_pin_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] lvl
);
    logic [WIDTH-1:0] chain [STAGES];

    // Stage 0 samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= pins;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-registers the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
// Module: cfg_shifter
// Serial shift register: shifts toward the MSB, reloads in parallel on a strobe.
// Assumes: load and shift_en are single-cycle pulses; load wins if both are set.
module cfg_shifter #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         load,
    input  logic [W-1:0] load_word,
    output logic [W-1:0] word_q,
    output logic         sdo
);
    logic [W-1:0] sr;

    // Shift-register update: parallel reload on a strobe, otherwise shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (load)     sr <= load_word;
        else if (shift_en) sr <= {sr[W-2:0], bit_in};
    end

    assign word_q = sr;
    assign sdo    = sr[W-1];

    // R2: a shift moves every bit one place up and inserts the input bit.
    p_shift_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> (sr[0] == $past(bit_in)) && (sr[W-1:1] == $past(sr[W-2:0])));

    // R7: with no shift and no load, the contents are held.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load) |=> $stable(sr));
endmodule

// File: rtl/cfg_holding_regs.sv
// Module: cfg_holding_regs
// Control and run-time holding registers, with a write lock on the control one.
// Assumes: load is a single-cycle pulse carrying the fully shifted word.
module cfg_holding_regs
    import cfg_serial_pkg::*;
#(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         wlock,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] run_q,
    output logic [W-1:0] readback
);
    cfg_target_e tgt;
    logic        ctrl_we;
    logic        run_we;

    // Decode which register this word addresses and whether it may be written.
    always_comb begin
        tgt     = target_of(word[0]);
        ctrl_we = load && (tgt == TGT_CTRL) && !wlock;
        run_we  = load && (tgt == TGT_RUN);
    end

    // Control register: written only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= word;
    end

    // Run-time register: no lock.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= '0;
        else if (run_we) run_q <= word;
    end

    // Value the shifter reloads: the addressed register as it stands after the strobe.
    always_comb begin
        if (tgt == TGT_CTRL && wlock) readback = ctrl_q;
        else                          readback = word;
    end

    // R4: a locked control write leaves the control register unchanged.
    p_lock_holds_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[0] && wlock) |=> $stable(ctrl_q));

    // R3: the control register only ever takes words whose select bit is 1.
    p_ctrl_sel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> ctrl_q[0]);

    // R5: the run-time register only ever takes words whose select bit is 0.
    p_run_sel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_q) |-> !run_q[0]);

    // R8: no strobe, no change to either register.
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(ctrl_q) && $stable(run_q)));
endmodule

// File: rtl/cfg_serial_port.sv
// Module: cfg_serial_port (top)
// Serial configuration port: synchronizes the pins, detects sck/str edges,
// shifts data and commits it into the holding registers.
// Assumes: clk runs several times faster than sck; str rises only with sck high.
module cfg_serial_port
    import cfg_serial_pkg::*;
#(
    parameter int unsigned W        = CFG_WORD_W,
    parameter int unsigned SYNC_LEN = CFG_SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         sck,
    input  logic         str,
    input  logic         wlock,
    output logic         sdo,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] run_q
);
    localparam int unsigned NPINS = 4;
    localparam int unsigned P_SDI = 0;
    localparam int unsigned P_SCK = 1;
    localparam int unsigned P_STR = 2;
    localparam int unsigned P_WLK = 3;

    logic [NPINS-1:0] pins_s;
    logic             sck_d;
    logic             str_d;
    logic             sck_rise;
    logic             str_rise;
    logic             do_load;
    logic             do_shift;
    logic [W-1:0]     sr_word;
    logic [W-1:0]     reload_word;

    cfg_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({wlock, str, sck, sdi}),
        .lvl   (pins_s)
    );

    // Previous synchronized levels of sck and str, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            str_d <= 1'b0;
        end else begin
            sck_d <= pins_s[P_SCK];
            str_d <= pins_s[P_STR];
        end
    end

    // Edge qualification: a strobe counts only with sck high; no shifting while str is high.
    always_comb begin
        sck_rise = pins_s[P_SCK] && !sck_d;
        str_rise = pins_s[P_STR] && !str_d;
        do_load  = str_rise && pins_s[P_SCK];
        do_shift = sck_rise && !pins_s[P_STR];
    end

    cfg_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (do_shift),
        .bit_in    (pins_s[P_SDI]),
        .load      (do_load),
        .load_word (reload_word),
        .word_q    (sr_word),
        .sdo       (sdo)
    );

    cfg_holding_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .word     (sr_word),
        .wlock    (pins_s[P_WLK]),
        .ctrl_q   (ctrl_q),
        .run_q    (run_q),
        .readback (reload_word)
    );

    // R7: a strobe edge seen while sck is low commits nothing.
    p_no_load_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (str_rise && !pins_s[P_SCK]) |=> ($stable(ctrl_q) && $stable(run_q)));

    // R1: the cycle after reset is released, both registers are zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (ctrl_q == '0 && run_q == '0 && !sdo));
endmodule

// File: tb/cfg_serial_port_test.sv
// Bench: scoreboard. Driver tasks push expected items; a monitor pops and compares them.
module cfg_serial_port_test;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sdi = 1'b0;
    logic         sck = 1'b0;
    logic         str = 1'b0;
    logic         wlock = 1'b0;
    logic         sdo;
    logic [W-1:0] ctrl_q;
    logic [W-1:0] run_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        bit           is_rb;
        logic [W-1:0] exp_c;
        logic [W-1:0] exp_r;
        logic [W-1:0] exp_rb;
        logic [W-1:0] got_rb;
        string        req;
    } item_t;

    item_t        q[$];
    logic [W-1:0] exp_ctrl = '0;
    logic [W-1:0] exp_run  = '0;

    cfg_serial_port uut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sck(sck), .str(str),
        .wlock(wlock), .sdo(sdo), .ctrl_q(ctrl_q), .run_q(run_q)
    );

    always #10 clk = ~clk;

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sck = 1'b0; sdi = b; wait_clk(4);
        sck = 1'b1;          wait_clk(4);
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic strobe();
        str = 1'b1; wait_clk(6);
        str = 1'b0; wait_clk(6);
    endtask

    // Shift a word, with a strobe pulse hidden in the low phase of the final bit (R7).
    task automatic shift_word_low_strobe(input logic [W-1:0] w);
        for (int i = W - 1; i >= 1; i--) shift_bit(w[i]);
        sck = 1'b0; sdi = w[0]; wait_clk(6);
        str = 1'b1; wait_clk(6);
        str = 1'b0; wait_clk(6);
        sck = 1'b1; wait_clk(6);
    endtask

    task automatic push_regs(input string req);
        item_t it;
        wait_clk(10);
        it.is_rb = 0; it.exp_c = exp_ctrl; it.exp_r = exp_run;
        it.exp_rb = '0; it.got_rb = '0; it.req = req;
        q.push_back(it);
    endtask

    // Shift out W bits (zeros in) and capture sdo before each rising sck.
    task automatic push_readback(input logic [W-1:0] expv, input string req);
        item_t        it;
        logic [W-1:0] cap;
        cap = '0;
        for (int i = W - 1; i >= 0; i--) begin
            sck = 1'b0; sdi = 1'b0; wait_clk(4);
            cap[i] = sdo;
            sck = 1'b1; wait_clk(4);
        end
        it.is_rb = 1; it.exp_c = '0; it.exp_r = '0;
        it.exp_rb = expv; it.got_rb = cap; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: pops each expected item and compares it against the ports.
    initial begin
        forever begin
            item_t it;
            wait (q.size() != 0);
            it = q.pop_front();
            if (it.is_rb) begin
                total++;
                if (it.got_rb !== it.exp_rb) begin
                    bad++;
                    $display("FAIL %s readback got=%h exp=%h", it.req, it.got_rb, it.exp_rb);
                end
            end else begin
                total++;
                if (ctrl_q !== it.exp_c || run_q !== it.exp_r) begin
                    bad++;
                    $display("FAIL %s ctrl=%h/%h run=%h/%h (got/exp)",
                             it.req, ctrl_q, it.exp_c, run_q, it.exp_r);
                end
            end
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        sck = 1'b1;
        wait_clk(6);
        // R1: reset state of registers and shift register.
        push_regs("R1");
        push_readback(20'h00000, "R1");

        // R3: unlocked control write.
        shift_word(20'hA5A51); strobe();
        exp_ctrl = 20'hA5A51;
        push_regs("R3");
        push_readback(20'hA5A51, "R6");

        // R5 and R8: run-time write while locked; control untouched.
        wlock = 1'b1;
        shift_word(20'h3C3C2); strobe();
        exp_run = 20'h3C3C2;
        push_regs("R5_R8");
        push_readback(20'h3C3C2, "R6");

        // R4: locked control write; readback returns the old control value.
        shift_word(20'h12345); strobe();
        push_regs("R4");
        push_readback(20'hA5A51, "R6");

        // R7: strobe while sck is low is ignored; R2: word shifts out MSB first.
        wlock = 1'b0;
        shift_word_low_strobe(20'h0F0F3);
        push_regs("R7");
        push_readback(20'h0F0F3, "R2");

        // R3: the same word strobed properly now lands.
        shift_word(20'h0F0F3); strobe();
        exp_ctrl = 20'h0F0F3;
        push_regs("R3");

        // R5: all-zero run-time word.
        shift_word(20'h00000); strobe();
        exp_run = 20'h00000;
        push_regs("R5");

        wait (q.size() == 0);
        wait_clk(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait_clk(150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule